// File: doc/BRIEF.md
# General Purpose Register File with 16-bit Pointer Pairs

This block holds the thirty-two byte-wide working registers of a small 8-bit controller datapath. A controller picks one of four port modes each cycle. Depending on the mode, the file hands out one or two byte operands, or one 16-bit register pair, and it accepts either a byte result or a 16-bit result that is split across an even/odd register pair. The six highest registers also appear at all times as three 16-bit pointer outputs (X, Y, Z), which address logic can use without spending a read port.

A second byte-wide port lets data-memory traffic reach the same storage. Addresses 0 to 31 on that port select a register directly. A read or write there behaves exactly like a direct register access. Addresses 32 and above do not belong to this block: reads return zero and writes have no effect. Reads on both ports are combinational. Writes land on the rising clock edge.

Top module: `gpr_pairfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to 0x00.
- R2: With `mode` = 2'b00, `rd_a` shows register `ra_idx`, and `rd_b` and `rd_w` read zero. When `wr_en` is high, `wr_data[7:0]` is written to register `ra_idx` and `wr_data[15:8]` is ignored. When `wr_en` is low, no register changes.
- R3: With `mode` = 2'b01, `rd_a` and `rd_b` show registers `ra_idx` and `rb_idx` together, and `rd_w` reads zero. When `wr_en` is high, `wr_data[7:0]` is written to register `wr_idx`.
- R4: With `mode` = 2'b10, `rd_a` and `rd_b` behave as in R3. When `wr_en` is high, `wr_data[7:0]` goes to even register `wr_idx` and `wr_data[15:8]` goes to register `wr_idx`+1.
- R5: With `mode` = 2'b11, `rd_w` = {reg[`ra_idx` with bit 0 set], reg[`ra_idx` with bit 0 cleared]}, and `rd_a` and `rd_b` read zero. When `wr_en` is high, the 16-bit `wr_data` is written to the pair at even index `ra_idx`, with the low byte in the even register.
- R6: A 16-bit write (mode 2'b10 or 2'b11) whose target index is odd changes no register. `err_odd` is high combinationally in that cycle, and it is low in every other case.
- R7: `ptr_x` = {R27,R26}, `ptr_y` = {R29,R28} and `ptr_z` = {R31,R30} at all times.
- R8: A read of a register that is being written in the same cycle returns the old value. The new value appears after the edge.
- R9: When `mem_en` is high and `mem_addr` < 32, `mem_hit` is high and `mem_rdata` shows register `mem_addr`. With `mem_we` also high, `mem_wdata` is written to that register at the edge. For any address of 32 or more, `mem_hit` is low, `mem_rdata` is zero and no register changes.
- R10: If a core-port write and an alias-port write hit the same register in the same cycle, the core-port value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Port mode select (00, 01, 10, 11) |
| ra_idx | input | 5 | First read index, also the write target in modes 00 and 11 |
| rb_idx | input | 5 | Second read index |
| wr_en | input | 1 | Core write enable |
| wr_idx | input | 5 | Write target in modes 01 and 10 |
| wr_data | input | 16 | Result to write (low byte only in byte modes) |
| rd_a | output | 8 | First byte operand |
| rd_b | output | 8 | Second byte operand |
| rd_w | output | 16 | 16-bit pair operand (mode 11) |
| err_odd | output | 1 | 16-bit write aimed at an odd index |
| ptr_x | output | 16 | Pointer view of R27:R26 |
| ptr_y | output | 16 | Pointer view of R29:R28 |
| ptr_z | output | 16 | Pointer view of R31:R30 |
| mem_en | input | 1 | Alias port access strobe |
| mem_we | input | 1 | Alias port write |
| mem_addr | input | 12 | Data-memory address on the alias port |
| mem_wdata | input | 8 | Alias write byte |
| mem_rdata | output | 8 | Alias read byte |
| mem_hit | output | 1 | Address falls inside the register window |

## Verification
The bench goes after the ways the write target can be picked wrongly. A design that used `wr_idx` in mode 00 or mode 11 would corrupt an unrelated register. A design that swapped the bytes of a pair would show reversed pointer halves. A design that wrote an odd-indexed pair would spill into the next pointer. It also checks that address 0x020 does not wrap back onto R0, which a design that only decoded the low five address bits would do. It further checks that a same-cycle read still returns the old value, and that a core write beats an alias write to the same register rather than losing to it.

// File: rtl/gpr_pairfile.sv
module gpr_pairfile #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int MAW  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode,
  input  logic [$clog2(NREG)-1:0]  ra_idx,
  input  logic [$clog2(NREG)-1:0]  rb_idx,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [2*DW-1:0]          wr_data,
  output logic [DW-1:0]            rd_a,
  output logic [DW-1:0]            rd_b,
  output logic [2*DW-1:0]          rd_w,
  output logic                     err_odd,
  output logic [2*DW-1:0]          ptr_x,
  output logic [2*DW-1:0]          ptr_y,
  output logic [2*DW-1:0]          ptr_z,
  input  logic                     mem_en,
  input  logic                     mem_we,
  input  logic [MAW-1:0]           mem_addr,
  input  logic [DW-1:0]            mem_wdata,
  output logic [DW-1:0]            mem_rdata,
  output logic                     mem_hit
);
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] M_ONE  = 2'b00;
  localparam logic [1:0] M_TWO  = 2'b01;
  localparam logic [1:0] M_TWOW = 2'b10;
  localparam logic [1:0] M_WIDE = 2'b11;
  localparam logic [MAW-1:0] WIN_TOP = MAW'(NREG);
  localparam logic [IW-1:0] XL = IW'(NREG - 6);
  localparam logic [IW-1:0] YL = IW'(NREG - 4);
  localparam logic [IW-1:0] ZL = IW'(NREG - 2);

  logic [DW-1:0] regs [NREG];

  logic          wide_wr;
  logic [IW-1:0] tgt, tgt_hi, ra_lo, ra_hi;
  logic          alias_wr;

  assign wide_wr = mode[1];
  assign tgt     = (mode == M_ONE || mode == M_WIDE) ? ra_idx : wr_idx;
  assign tgt_hi  = {tgt[IW-1:1], 1'b1};
  assign ra_lo   = {ra_idx[IW-1:1], 1'b0};
  assign ra_hi   = {ra_idx[IW-1:1], 1'b1};
  assign err_odd = wr_en && wide_wr && tgt[0];

  assign rd_a = (mode == M_WIDE) ? '0 : regs[ra_idx];
  assign rd_b = (mode == M_TWO || mode == M_TWOW) ? regs[rb_idx] : '0;
  assign rd_w = (mode == M_WIDE) ? {regs[ra_hi], regs[ra_lo]} : '0;

  assign ptr_x = {regs[XL + IW'(1)], regs[XL]};
  assign ptr_y = {regs[YL + IW'(1)], regs[YL]};
  assign ptr_z = {regs[ZL + IW'(1)], regs[ZL]};

  assign mem_hit   = mem_en && (mem_addr < WIN_TOP);
  assign mem_rdata = mem_hit ? regs[mem_addr[IW-1:0]] : '0;
  assign alias_wr  = mem_hit && mem_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (alias_wr) regs[mem_addr[IW-1:0]] <= mem_wdata;
      if (wr_en) begin
        if (!wide_wr) begin
          regs[tgt] <= wr_data[DW-1:0];
        end else if (!tgt[0]) begin
          regs[tgt]    <= wr_data[DW-1:0];
          regs[tgt_hi] <= wr_data[2*DW-1:DW];
        end
      end
    end
  end
endmodule

// File: rtl/gpr_pairfile_chk.sv
module gpr_pairfile_chk #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int MAW  = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              mode,
  input logic [$clog2(NREG)-1:0] ra_idx,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [2*DW-1:0]         wr_data,
  input logic                    err_odd,
  input logic [2*DW-1:0]         ptr_x,
  input logic [2*DW-1:0]         ptr_y,
  input logic [2*DW-1:0]         ptr_z,
  input logic                    mem_en,
  input logic                    mem_we,
  input logic [MAW-1:0]          mem_addr,
  input logic [DW-1:0]           mem_rdata
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0]  XL  = IW'(NREG - 6);
  localparam logic [IW-1:0]  ZL  = IW'(NREG - 2);
  localparam logic [MAW-1:0] AXL = MAW'(NREG - 6);
  localparam logic [MAW-1:0] TOP = MAW'(NREG);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0));

  p_pair_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b11 && ra_idx == ZL && !(mem_en && mem_we))
    |=> ptr_z == $past(wr_data));

  p_odd_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (err_odd && !(mem_en && mem_we))
    |=> ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

  p_byte_low_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b01 && wr_idx == XL && !(mem_en && mem_we))
    |=> (ptr_x[DW-1:0] == $past(wr_data[DW-1:0]) && $stable(ptr_x[2*DW-1:DW])));

  p_alias_read_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_addr == AXL) |-> mem_rdata == ptr_x[DW-1:0]);

  p_alias_outside_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_addr >= TOP) |-> mem_rdata == '0);

  p_core_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 2'b01 && wr_idx == XL && mem_en && mem_we && mem_addr == AXL)
    |=> ptr_x[DW-1:0] == $past(wr_data[DW-1:0]));
endmodule

bind gpr_pairfile gpr_pairfile_chk #(.NREG(NREG), .DW(DW), .MAW(MAW)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .ra_idx(ra_idx), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .err_odd(err_odd), .ptr_x(ptr_x),
  .ptr_y(ptr_y), .ptr_z(ptr_z), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata)
);

// File: tb/gpr_pairfile_bench.sv
module gpr_pairfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic [4:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_a, rd_b;
  logic [15:0] rd_w, ptr_x, ptr_y, ptr_z;
  logic        err_odd;
  logic        mem_en = 1'b0, mem_we = 1'b0;
  logic [11:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        mem_hit;

  int tests = 0;
  int fails = 0;
  logic [7:0] m [32];

  always #4 clk = ~clk;

  gpr_pairfile u_gpr_pairfile (
    .clk(clk), .rst(rst), .mode(mode), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b),
    .rd_w(rd_w), .err_odd(err_odd), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit)
  );

  // {mode, ra, rb, wr_idx, data}
  localparam logic [32:0] VEC [12] = '{
    {2'b01, 5'd0,  5'd1,  5'd5,  16'h00A5},
    {2'b00, 5'd5,  5'd0,  5'd7,  16'h003C},
    {2'b10, 5'd5,  5'd0,  5'd26, 16'h1234},
    {2'b11, 5'd26, 5'd0,  5'd3,  16'hBEEF},
    {2'b11, 5'd29, 5'd0,  5'd2,  16'h5555},
    {2'b10, 5'd0,  5'd0,  5'd31, 16'hFFFF},
    {2'b10, 5'd26, 5'd27, 5'd30, 16'hC0DE},
    {2'b11, 5'd28, 5'd0,  5'd9,  16'h8001},
    {2'b01, 5'd31, 5'd30, 5'd0,  16'h0077},
    {2'b00, 5'd0,  5'd0,  5'd4,  16'h1188},
    {2'b01, 5'd0,  5'd0,  5'd31, 16'h00AB},
    {2'b11, 5'd30, 5'd0,  5'd1,  16'h0000}
  };

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all_regs(input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      mem_en = 1'b1; mem_we = 1'b0; mem_addr = 12'(i);
      #1;
      chk(req, $sformatf("alias read R%0d", i), {8'h00, mem_rdata}, {8'h00, m[i]});
    end
    mem_en = 1'b0;
  endtask

  task automatic check_ptrs(input string req);
    chk(req, "ptr_x", ptr_x, {m[27], m[26]});
    chk(req, "ptr_y", ptr_y, {m[29], m[28]});
    chk(req, "ptr_z", ptr_z, {m[31], m[30]});
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_ptrs("R1 R7");
    check_all_regs("R1");

    for (int v = 0; v < 12; v++) begin
      logic [1:0] md; logic [4:0] a, b, w, t; logic [15:0] d;
      logic [7:0] ea, eb; logic [15:0] ew; logic eo;
      {md, a, b, w, d} = VEC[v];
      @(negedge clk);
      mode = md; ra_idx = a; rb_idx = b; wr_idx = w; wr_data = d; wr_en = 1'b1;
      #1;
      t  = (md == 2'b00 || md == 2'b11) ? a : w;
      eo = md[1] && t[0];
      ea = (md == 2'b11) ? 8'h00 : m[a];
      eb = (md == 2'b01 || md == 2'b10) ? m[b] : 8'h00;
      ew = (md == 2'b11) ? {m[{a[4:1], 1'b1}], m[{a[4:1], 1'b0}]} : 16'h0000;
      chk(md == 2'b00 ? "R2" : md == 2'b01 ? "R3" : md == 2'b10 ? "R4" : "R5",
          $sformatf("vec %0d rd_a", v), {8'h00, rd_a}, {8'h00, ea});
      chk("R3 R4", $sformatf("vec %0d rd_b", v), {8'h00, rd_b}, {8'h00, eb});
      chk("R5", $sformatf("vec %0d rd_w", v), rd_w, ew);
      chk("R6", $sformatf("vec %0d err_odd", v), {15'h0, err_odd}, {15'h0, eo});
      @(posedge clk);
      if (!md[1]) m[t] = d[7:0];
      else if (!t[0]) begin m[t] = d[7:0]; m[{t[4:1], 1'b1}] = d[15:8]; end
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check_ptrs("R7 R4 R5 R6");
    end
    check_all_regs("R2 R3 R4 R5 R6");

    // R2: wr_en low writes nothing
    @(negedge clk);
    mode = 2'b00; ra_idx = 5'd9; wr_data = 16'h00EE; wr_en = 1'b0;
    @(negedge clk);
    mem_en = 1'b1; mem_addr = 12'd9; #1;
    chk("R2", "no write when wr_en low", {8'h00, mem_rdata}, {8'h00, m[9]});
    mem_en = 1'b0;

    // R8: read during write sees old value
    @(negedge clk);
    mode = 2'b01; ra_idx = 5'd12; rb_idx = 5'd12; wr_idx = 5'd12; wr_data = 16'h005A; wr_en = 1'b1;
    #1;
    chk("R8", "rd_a during write", {8'h00, rd_a}, {8'h00, m[12]});
    @(posedge clk); m[12] = 8'h5A;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R8", "rd_a after write", {8'h00, rd_a}, 16'h005A);

    // R9: alias write inside window, then reach it via core port
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = 12'd17; mem_wdata = 8'h3D;
    #1;
    chk("R9", "mem_hit inside", {15'h0, mem_hit}, 16'h0001);
    @(posedge clk); m[17] = 8'h3D;
    @(negedge clk); mem_we = 1'b0; mem_en = 1'b0;
    mode = 2'b00; ra_idx = 5'd17; #1;
    chk("R9", "core sees alias write", {8'h00, rd_a}, 16'h003D);

    // R9: out of window write ignored, no wrap onto R0
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = 12'h020; mem_wdata = 8'hF0;
    #1;
    chk("R9", "mem_hit outside", {15'h0, mem_hit}, 16'h0000);
    chk("R9", "mem_rdata outside", {8'h00, mem_rdata}, 16'h0000);
    @(negedge clk);
    mem_addr = 12'h8FF; mem_wdata = 8'h0F;
    @(negedge clk);
    mem_we = 1'b0; mem_addr = 12'h000; #1;
    chk("R9", "R0 untouched by 0x020", {8'h00, mem_rdata}, {8'h00, m[0]});
    mem_addr = 12'd31; #1;
    chk("R9", "R31 untouched by 0x8FF", {8'h00, mem_rdata}, {8'h00, m[31]});
    mem_en = 1'b0;

    // R10: collision, core wins
    @(negedge clk);
    mode = 2'b01; wr_idx = 5'd26; wr_data = 16'h0066; wr_en = 1'b1;
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = 12'd26; mem_wdata = 8'h99;
    @(posedge clk); m[26] = 8'h66;
    @(negedge clk); wr_en = 1'b0; mem_we = 1'b0; mem_en = 1'b0; #1;
    chk("R10", "core beats alias", ptr_x, {m[27], 8'h66});

    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    #1;
    check_ptrs("R1");
    check_all_regs("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule